// File: doc/BRIEF.md
# Critical Temperature Shutdown Monitor

This block watches a set of signed temperature readings and pulls a system shutdown line when any participating channel reaches its critical limit. Each reading arrives with its own valid strobe; on that strobe the channel compares the reading against its limit and keeps the result until its next sample. A number of channels are software channels that take part only when software has tied them to the shutdown line. One extra hardware channel always takes part.

Next to the shutdown line, the block keeps a sticky cause register. It records which channel drove the line high. The shutdown line drops by itself once every participating channel reads below its limit again. A cause bit stays set until the host reads the register. A read clears the register. A channel that is still too hot sets its bit again on its next sample, so a fault that persists is never lost.

Top module: `crit_shdn_mon`

## Requirements
- R1: On a valid strobe for a channel, the reading and the limit are compared as signed two's-complement values. The channel is hot when the reading is greater than or equal to the limit. Equality counts as hot. The result is held until that channel's next strobe, and a limit change alone has no effect.
- R2: `shdn_o` is high in the cycle after a strobe if any participating channel is hot. It is the OR of the hardware channel's hot state and, for each software channel, its hot state ANDed with its enable bit.
- R3: A software channel whose bit in `assoc_en_i` is 0 never raises `shdn_o` and never sets its cause bit, whatever its reading.
- R4: The hardware channel is channel index NUM_SW, the topmost slice of the buses. It always takes part. When its sample is hot, it sets bit 7 of `stat_o`.
- R5: A hot sample of software channel c (c = 0 to 3) sets bit c of `stat_o`. Bits 4 to 6 always read 0.
- R6: `shdn_o` drops in the cycle after a strobe that puts every participating channel below its limit. The cause bits stay set.
- R7: A clock edge with `stat_rd_i` high clears the cause register. If a hot sample lands on the same edge, its bit is set after that edge.
- R8: After a read, a channel that is still hot sets its cause bit again on its next valid sample.
- R9: After reset, `shdn_o` is 0 and `stat_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | (NUM_SW+1)*TEMP_W | Packed signed readings. Channel c sits at bits [c*TEMP_W +: TEMP_W]. |
| temp_vld_i | input | NUM_SW+1 | Per-channel sample strobe |
| limit_i | input | (NUM_SW+1)*TEMP_W | Packed signed critical limits, in the same layout as temp_i |
| assoc_en_i | input | NUM_SW | Per software channel: 1 lets the channel drive shutdown |
| stat_rd_i | input | 1 | Host read of the cause register. The register clears on the edge. |
| shdn_o | output | 1 | System shutdown request |
| stat_o | output | 8 | Sticky cause register |

## Verification
The bench sweeps every 8-bit reading on every channel against limits at both ends of the signed range, at -1, at 0 and at a typical value. A design that compared unsigned would flip at the sign boundary. A design that used strict greater-than would miss the equality points. Every enable mask is walked with all channels hot, so a design that ignored the enable, or mapped a channel to the wrong cause bit, would show a wrong status byte. Directed sequences check three more cases. Shutdown must release while its cause stays latched. A read must land on the same edge as a hot sample without losing it. A channel that stays hot must re-set its bit after a read. A design that cleared the cause on release, or let the read win, would fail these.

// File: rtl/crit_mon_pkg.sv
package crit_mon_pkg;
   localparam int STAT_W = 8;
   localparam int HW_BIT = 7;

   // position in the cause register that channel ch reports on
   function automatic int cause_pos(input int ch, input int nsw);
      return (ch < nsw) ? ch : HW_BIT;
   endfunction
endpackage

// File: rtl/crit_chan_cmp.sv
module crit_chan_cmp #(
   parameter int TEMP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld_i,
   input  logic [TEMP_W-1:0] temp_i,
   input  logic [TEMP_W-1:0] limit_i,
   output logic              ge_now_o,
   output logic              hot_o
);
   logic hot_q;

   assign ge_now_o = ($signed(temp_i) >= $signed(limit_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hot_q <= 1'b0;
      else if (smp_vld_i) hot_q <= ge_now_o;
   end

   assign hot_o = hot_q;
endmodule

// File: rtl/crit_stat_reg.sv
module crit_stat_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] stat_o
);
   logic [W-1:0] stat_q;
   logic [W-1:0] stat_d;

   // a set arriving on the clearing edge survives it
   always_comb stat_d = (clr_i ? '0 : stat_q) | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign stat_o = stat_q;
endmodule

// File: rtl/crit_shdn_drv.sv
module crit_shdn_drv #(
   parameter int NCH  = 5,
   parameter bit PIPE = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] hot_i,
   output logic           shdn_o
);
   logic any_hot;
   assign any_hot = |hot_i;

   generate
      if (PIPE) begin : g_reg
         logic shdn_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shdn_q <= 1'b0;
            else        shdn_q <= any_hot;
         end
         assign shdn_o = shdn_q;
      end else begin : g_comb
         assign shdn_o = any_hot;
      end
   endgenerate
endmodule

// File: rtl/crit_shdn_mon.sv
module crit_shdn_mon
   import crit_mon_pkg::*;
#(
   parameter int NUM_SW    = 4,
   parameter int TEMP_W    = 8,
   parameter bit SHDN_PIPE = 1'b0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [(NUM_SW+1)*TEMP_W-1:0]   temp_i,
   input  logic [NUM_SW:0]                temp_vld_i,
   input  logic [(NUM_SW+1)*TEMP_W-1:0]   limit_i,
   input  logic [NUM_SW-1:0]              assoc_en_i,
   input  logic                           stat_rd_i,
   output logic                           shdn_o,
   output logic [STAT_W-1:0]              stat_o
);
   localparam int NCH = NUM_SW + 1;
   localparam int HWC = NUM_SW;

   initial begin
      if (NUM_SW < 1 || NUM_SW > HW_BIT)
         $error("crit_shdn_mon: NUM_SW must be in 1..%0d", HW_BIT);
      if (TEMP_W < 2)
         $error("crit_shdn_mon: TEMP_W must be at least 2");
   end

   logic [NCH-1:0]    ge_now;
   logic [NCH-1:0]    hot;
   logic [NCH-1:0]    gate;
   logic [NCH-1:0]    hot_gated;
   logic [NCH-1:0]    ch_set;
   logic [STAT_W-1:0] set_vec;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         crit_chan_cmp #(.TEMP_W(TEMP_W)) cmp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_vld_i (temp_vld_i[c]),
            .temp_i    (temp_i[c*TEMP_W +: TEMP_W]),
            .limit_i   (limit_i[c*TEMP_W +: TEMP_W]),
            .ge_now_o  (ge_now[c]),
            .hot_o     (hot[c])
         );
         if (c == HWC) begin : g_hw
            assign gate[c] = 1'b1;
         end else begin : g_sw
            assign gate[c] = assoc_en_i[c];
         end
         assign hot_gated[c] = hot[c] & gate[c];
         assign ch_set[c]    = temp_vld_i[c] & ge_now[c] & gate[c];
      end

      for (genvar b = 0; b < STAT_W; b++) begin : g_bit
         if (b < NUM_SW) begin : g_sw_bit
            assign set_vec[b] = ch_set[b];
         end else if (b == HW_BIT) begin : g_hw_bit
            assign set_vec[b] = ch_set[HWC];
         end else begin : g_rsvd
            assign set_vec[b] = 1'b0;
         end
      end
   endgenerate

   crit_stat_reg #(.W(STAT_W)) stat_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (stat_rd_i),
      .stat_o (stat_o)
   );

   crit_shdn_drv #(.NCH(NCH), .PIPE(SHDN_PIPE)) drv_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .hot_i  (hot_gated),
      .shdn_o (shdn_o)
   );
endmodule

// File: rtl/crit_shdn_mon_chk.sv
module crit_shdn_mon_chk #(
   parameter int NUM_SW = 4,
   parameter int TEMP_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [(NUM_SW+1)*TEMP_W-1:0] temp_i,
   input logic [NUM_SW:0]              temp_vld_i,
   input logic [(NUM_SW+1)*TEMP_W-1:0] limit_i,
   input logic [NUM_SW-1:0]            assoc_en_i,
   input logic                         stat_rd_i,
   input logic                         shdn_o,
   input logic [7:0]                   stat_o
);
   logic hw_hot_smp;
   assign hw_hot_smp = temp_vld_i[NUM_SW] &&
      ($signed(temp_i[NUM_SW*TEMP_W +: TEMP_W]) >= $signed(limit_i[NUM_SW*TEMP_W +: TEMP_W]));

   // R3: a software cause bit only rises after an enabled sample of that channel
   a_r3_no_unassoc_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_o[NUM_SW-1:0] & ~$past(stat_o[NUM_SW-1:0])) &
       ~$past(assoc_en_i & temp_vld_i[NUM_SW-1:0])) == '0);

   // R5: unused positions stay clear
   a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[6:NUM_SW] == '0);

   // R6: without a read no cause bit falls
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

   // R4: a hot hardware sample always records bit 7
   a_r4_hw_cause: assert property (@(posedge clk) disable iff (!rst_n)
      hw_hot_smp |=> stat_o[7]);

   // R7: a read with no sample in flight empties the register
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && temp_vld_i == '0) |=> stat_o == 8'h00);
endmodule

bind crit_shdn_mon crit_shdn_mon_chk #(.NUM_SW(NUM_SW), .TEMP_W(TEMP_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .temp_i     (temp_i),
   .temp_vld_i (temp_vld_i),
   .limit_i    (limit_i),
   .assoc_en_i (assoc_en_i),
   .stat_rd_i  (stat_rd_i),
   .shdn_o     (shdn_o),
   .stat_o     (stat_o)
);

// File: tb/crit_shdn_mon_tb_top.sv
`timescale 1ns/1ps
module crit_shdn_mon_tb_top;
   localparam int NSW = 4;
   localparam int TW  = 8;
   localparam int NCH = NSW + 1;
   localparam int HWC = NSW;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NCH*TW-1:0]   temp = '0;
   logic [NCH-1:0]      vld = '0;
   logic [NCH*TW-1:0]   lim = '0;
   logic [NSW-1:0]      assoc = '0;
   logic                rd = 1'b0;
   logic                shdn;
   logic [7:0]          stat;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;
   bit  exp_over [NCH];
   int  exp_lim  [NCH];
   logic [7:0] exp_stat = 8'h00;

   always #2.5 clk = ~clk;

   crit_shdn_mon #(.NUM_SW(NSW), .TEMP_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .temp_i(temp), .temp_vld_i(vld), .limit_i(lim),
      .assoc_en_i(assoc), .stat_rd_i(rd), .shdn_o(shdn), .stat_o(stat));

   function automatic int bitpos(int ch);
      return (ch < NSW) ? ch : 7;
   endfunction

   function automatic bit takes_part(int ch);
      return (ch == HWC) ? 1'b1 : assoc[ch];
   endfunction

   function automatic bit exp_shdn();
      bit r = 1'b0;
      for (int c = 0; c < NCH; c++) if (exp_over[c] && takes_part(c)) r = 1'b1;
      return r;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_lim(int ch, int v);
      lim[ch*TW +: TW] = v[TW-1:0];
      exp_lim[ch] = v;
   endtask

   // drive one sample at a negedge, consumed at the next posedge
   task automatic drive_smp(int ch, int t);
      temp[ch*TW +: TW] = t[TW-1:0];
      vld[ch] = 1'b1;
      exp_over[ch] = (t >= exp_lim[ch]);
      if (exp_over[ch] && takes_part(ch)) exp_stat[bitpos(ch)] = 1'b1;
   endtask

   task automatic sample(int ch, int t);
      @(negedge clk);
      drive_smp(ch, t);
      @(negedge clk);
      vld = '0;
   endtask

   task automatic check_out(string req);
      chk({req, " shdn"}, {7'd0, shdn}, {7'd0, exp_shdn()});
      chk({req, " stat"}, stat, exp_stat);
   endtask

   task automatic host_read(string req);
      @(negedge clk);
      chk({req, " stat before read"}, stat, exp_stat);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      exp_stat = 8'h00;
      chk({req, " stat after read"}, stat, exp_stat);
   endtask

   task automatic quiet_all();
      for (int c = 0; c < NCH; c++) begin
         set_lim(c, 127);
         sample(c, -128);
      end
      host_read("R7 quiet");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
         $finish;
      end
   end

   initial begin
      int lims [5] = '{-128, -1, 0, 85, 127};
      for (int c = 0; c < NCH; c++) begin exp_over[c] = 1'b0; exp_lim[c] = 0; end
      repeat (3) @(negedge clk);
      // R9: reset values
      chk("R9 shdn at reset", {7'd0, shdn}, 8'h00);
      chk("R9 stat at reset", stat, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      assoc = '1;

      // R1 R2 R4 R5 R8: full sweep of readings per channel and limit
      for (int ch = 0; ch < NCH; ch++) begin
         for (int li = 0; li < 5; li++) begin
            quiet_all();
            set_lim(ch, lims[li]);
            for (int t = -128; t <= 127; t++) begin
               sample(ch, t);
               check_out(ch == HWC ? "R4 sweep" : "R1 R2 R5 sweep");
               host_read("R8 sweep");
            end
         end
      end

      // R3: every enable mask with all channels hot, hardware channel cold
      for (int m = 0; m < (1 << NSW); m++) begin
         assoc = '0;
         quiet_all();
         assoc = m[NSW-1:0];
         for (int c = 0; c < NSW; c++) begin set_lim(c, 50); sample(c, 100); end
         check_out("R3 mask");
         host_read("R3 mask");
         // R1: a limit change alone leaves the held result
         for (int c = 0; c < NSW; c++) set_lim(c, 127);
         @(negedge clk);
         check_out("R1 limit change only");
      end

      // R4: hardware channel hot with no software enable
      assoc = '0;
      quiet_all();
      set_lim(HWC, 90);
      sample(HWC, 90);
      check_out("R4 hw only");

      // R6: release keeps the cause latched
      sample(HWC, 89);
      check_out("R6 release");
      chk("R6 cause kept", stat, 8'h80);
      host_read("R6 read");

      // R7: read and hot sample on the same edge
      assoc = 4'b0100;
      quiet_all();
      set_lim(2, 0);
      sample(2, 5);
      @(negedge clk);
      rd = 1'b1;
      exp_stat = 8'h00;
      drive_smp(2, 7);
      @(negedge clk);
      rd = 1'b0;
      vld = '0;
      check_out("R7 coincident set");
      chk("R7 coincident value", stat, 8'h04);

      // R8: persistent fault reappears after read
      host_read("R8 read");
      sample(2, 7);
      check_out("R8 persistent");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule